// File: doc/BRIEF.md
# Flagged Byte I/O Interrupt Interface

This block sits between a small accumulator CPU and two byte-wide peripherals: one that produces bytes and one that consumes them. Each side is handshaked through a single flag. The producing peripheral pulses a strobe that writes its byte into an input holding register and raises the input-ready flag. The consuming peripheral pulses a request strobe that raises the output-wanted flag. No CPU operation can raise either flag. The CPU lowers them only by moving data: reading the input byte or writing an output byte.

On the CPU side the block executes six I/O operations. Each is selected by one bit of a six-bit select field, taken from the instruction word, and qualified by an I/O execute strobe. The operations are:
- read the input byte into the accumulator's low byte;
- write the accumulator's low byte to the output holding register;
- skip if input is ready;
- skip if output is wanted;
- enable interrupts;
- disable interrupts.

The block returns a combinational skip request to the program counter logic. It raises an interrupt request whenever interrupts are enabled and either flag is up. The CPU's interrupt-cycle acknowledge disables interrupts again. Servicing the interrupt belongs to the CPU.

Top module: `byte_io_irq_if`

## Requirements
- R1: After a synchronous active-low reset, both flags, the interrupt enable, the output-valid pulse and both holding registers are 0.
- R2: A cycle with `in_strobe` high loads `in_data` into the input holding register (seen on `inp_data`) and sets `in_flag`, both visible after that clock edge.
- R3: A cycle with `out_req` high sets `out_flag`, visible after that clock edge.
- R4: The read-input op (`io_sel[5]` with `io_exec`) raises `inp_load` in the same cycle with `inp_data` showing the held byte, and clears `in_flag` at the clock edge.
- R5: The write-output op (`io_sel[4]` with `io_exec`) loads `acc_lo` into `out_data` and clears `out_flag` at the clock edge. `out_valid` is high for exactly the one cycle after each such op.
- R6: `skip` is high in the same cycle when `io_sel[3]` is executed with `in_flag`=1, or when `io_sel[2]` is executed with `out_flag`=1. Otherwise it is low.
- R7: The enable op (`io_sel[1]`) sets `irq_en`. The disable op (`io_sel[0]`) and `irq_ack` clear it. When an enable and a clear fall in the same cycle, the clear wins.
- R8: `irq` equals `irq_en` AND (`in_flag` OR `out_flag`). A flag raised while `irq_en`=0 stays set and raises `irq` as soon as interrupts are enabled.
- R9: When the external set and the CPU clear of the same flag fall in the same cycle, the flag ends up set.
- R10: With `io_exec` low, `io_sel` has no effect: no skip, no input load, no output update, and flags and `irq_en` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_strobe | input | 1 | Producer writes `in_data` and raises the input flag |
| in_data | input | DATA_W | Byte from the producer |
| out_req | input | 1 | Consumer asks for a byte, raising the output flag |
| io_exec | input | 1 | CPU executes an I/O instruction this cycle |
| io_sel | input | 6 | Op select: [5] read input, [4] write output, [3] skip-if-input, [2] skip-if-output, [1] enable, [0] disable |
| acc_lo | input | DATA_W | Accumulator low byte |
| irq_ack | input | 1 | Interrupt-cycle acknowledge; clears the enable |
| inp_data | output | DATA_W | Input holding register toward the accumulator |
| inp_load | output | 1 | Accumulator low byte should load `inp_data` this cycle |
| out_data | output | DATA_W | Output holding register toward the consumer |
| out_valid | output | 1 | One-cycle pulse after a new output byte is written |
| in_flag | output | 1 | Input-ready flag |
| out_flag | output | 1 | Output-wanted flag |
| irq_en | output | 1 | Interrupt enable |
| skip | output | 1 | Skip request to the program counter |
| irq | output | 1 | Interrupt request |

## Verification
Two of this block's functions can fall in the same cycle: the peripheral setting a flag and the CPU transfer that clears it. The bench drives `in_strobe` together with a read-input op, and `out_req` together with a write-output op. It judges that the flag is still set afterwards and that the data transfer still took place. The same-cycle enable-versus-clear case is provoked with both enable and disable bits together, and again with enable plus `irq_ack`. Here the enable must end low.

// File: rtl/io_if_pkg.sv
// Package: shared op indices and decoded-op type for the byte I/O interface.
// Assumes the select field is six bits, one bit per I/O op.
package io_if_pkg;
    localparam int OP_COUNT = 6;
    localparam int OP_INP   = 5;
    localparam int OP_OUT   = 4;
    localparam int OP_SKI   = 3;
    localparam int OP_SKO   = 2;
    localparam int OP_ION   = 1;
    localparam int OP_IOF   = 0;

    typedef struct packed {
        logic rd_in;
        logic wr_out;
        logic skip_in;
        logic skip_out;
        logic en_irq;
        logic dis_irq;
    } io_ops_t;
endpackage

// File: rtl/io_op_decode.sv
// Module: gates each select bit with the execute strobe and packs the result.
// Assumes several select bits may be set at once; each op acts independently.
module io_op_decode
    import io_if_pkg::*;
(
    input  logic                io_exec,
    input  logic [OP_COUNT-1:0] io_sel,
    output io_ops_t             ops
);
    logic [OP_COUNT-1:0] gated;

    // Qualify every select bit with the execute strobe.
    for (genvar g = 0; g < OP_COUNT; g++) begin : g_gate
        assign gated[g] = io_exec & io_sel[g];
    end

    // Map qualified bits onto named op fields.
    always_comb begin
        ops.rd_in    = gated[OP_INP];
        ops.wr_out   = gated[OP_OUT];
        ops.skip_in  = gated[OP_SKI];
        ops.skip_out = gated[OP_SKO];
        ops.en_irq   = gated[OP_ION];
        ops.dis_irq  = gated[OP_IOF];
    end
endmodule

// File: rtl/io_flag.sv
// Module: one handshake flag; the external set beats the CPU clear in the same cycle.
// Assumes synchronous active-low reset.
module io_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);
    // Flag state with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(flag_q)); // R8
endmodule

// File: rtl/io_data_reg.sv
// Module: byte holding register with a load enable.
// Assumes synchronous active-low reset to zero.
module io_data_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the byte when loaded, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/byte_io_irq_if.sv
// Module: flagged byte I/O interface with interrupt request.
// Holds one input byte and one output byte, each with a handshake flag that only
// the peripheral can raise. It executes six CPU I/O ops and returns skip and irq.
// Assumes: io_sel bits follow io_if_pkg indices; skip and inp_load are combinational
// in the execute cycle; synchronous active-low reset.
module byte_io_irq_if
    import io_if_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_strobe,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                out_req,
    input  logic                io_exec,
    input  logic [OP_COUNT-1:0] io_sel,
    input  logic [DATA_W-1:0]   acc_lo,
    input  logic                irq_ack,
    output logic [DATA_W-1:0]   inp_data,
    output logic                inp_load,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_valid,
    output logic                in_flag,
    output logic                out_flag,
    output logic                irq_en,
    output logic                skip,
    output logic                irq
);
    localparam int N_FLAGS = 2;
    localparam int F_IN    = 0;
    localparam int F_OUT   = 1;

    io_ops_t            ops;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_clr;
    logic [N_FLAGS-1:0] flag_q;
    logic               ien_q;
    logic               ovalid_q;

    io_op_decode u_dec (
        .io_exec (io_exec),
        .io_sel  (io_sel),
        .ops     (ops)
    );

    // Route peripheral strobes to flag sets and CPU transfers to flag clears.
    always_comb begin
        flag_set[F_IN]  = in_strobe;
        flag_set[F_OUT] = out_req;
        flag_clr[F_IN]  = ops.rd_in;
        flag_clr[F_OUT] = ops.wr_out;
    end

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
        io_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (flag_set[f]),
            .clr    (flag_clr[f]),
            .flag_q (flag_q[f])
        );
    end

    io_data_reg #(.W(DATA_W)) u_in_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_strobe),
        .d     (in_data),
        .q     (inp_data)
    );

    io_data_reg #(.W(DATA_W)) u_out_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ops.wr_out),
        .d     (acc_lo),
        .q     (out_data)
    );

    // Interrupt enable: a clear (disable op or acknowledge) beats an enable op.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ien_q <= 1'b0;
        else if (ops.dis_irq || irq_ack)  ien_q <= 1'b0;
        else if (ops.en_irq)              ien_q <= 1'b1;
    end

    // One-cycle output-valid pulse following each write-output op.
    always_ff @(posedge clk) begin
        if (!rst_n) ovalid_q <= 1'b0;
        else        ovalid_q <= ops.wr_out;
    end

    // Outputs toward the CPU and the peripherals.
    always_comb begin
        inp_load  = ops.rd_in;
        skip      = (ops.skip_in & flag_q[F_IN]) | (ops.skip_out & flag_q[F_OUT]);
        irq       = ien_q & (|flag_q);
        in_flag   = flag_q[F_IN];
        out_flag  = flag_q[F_OUT];
        irq_en    = ien_q;
        out_valid = ovalid_q;
    end

    AST_INPR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> (inp_data == $past(in_data))); // R2
    AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_exec && io_sel[OP_OUT]) |=> (out_valid && out_data == $past(acc_lo))); // R5
    AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_exec && io_sel[OP_OUT]) |=> !out_valid); // R5
    AST_IEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_exec && io_sel[OP_IOF]) || irq_ack) |=> !irq_en); // R7
    AST_IEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (io_exec && io_sel[OP_ION] && !io_sel[OP_IOF] && !irq_ack) |=> irq_en); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !io_exec |-> (!skip && !inp_load)); // R10
endmodule

// File: tb/test_byte_io_irq_if.sv
`timescale 1ns/1ps
module test_byte_io_irq_if;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_strobe, out_req, io_exec, irq_ack;
    logic [7:0] in_data, acc_lo;
    logic [5:0] io_sel;
    logic [7:0] inp_data, out_data;
    logic       inp_load, out_valid, in_flag, out_flag, irq_en, skip, irq;

    int checks = 0;
    int errors = 0;

    // Select bit positions: [5] read input, [4] write output, [3] skip-in,
    // [2] skip-out, [1] enable, [0] disable.
    localparam logic [5:0] S_INP = 6'b100000;
    localparam logic [5:0] S_OUT = 6'b010000;
    localparam logic [5:0] S_SKI = 6'b001000;
    localparam logic [5:0] S_SKO = 6'b000100;
    localparam logic [5:0] S_ION = 6'b000010;
    localparam logic [5:0] S_IOF = 6'b000001;

    always #2.5 clk = ~clk;

    byte_io_irq_if i_byte_io_irq_if (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .in_data(in_data),
        .out_req(out_req), .io_exec(io_exec), .io_sel(io_sel), .acc_lo(acc_lo),
        .irq_ack(irq_ack), .inp_data(inp_data), .inp_load(inp_load),
        .out_data(out_data), .out_valid(out_valid), .in_flag(in_flag),
        .out_flag(out_flag), .irq_en(irq_en), .skip(skip), .irq(irq)
    );

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Advance one clock edge; inputs change and checks sample at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        in_strobe = 0; out_req = 0; io_exec = 0; io_sel = '0; irq_ack = 0;
    endtask

    task automatic exec_op(input logic [5:0] sel);
        io_exec = 1; io_sel = sel;
    endtask

    task automatic t_reset();
        check(in_flag, 0, "R1 in_flag");
        check(out_flag, 0, "R1 out_flag");
        check(irq_en, 0, "R1 irq_en");
        check(out_valid, 0, "R1 out_valid");
        check(out_data, 0, "R1 out_data");
        check(inp_data, 0, "R1 inp_data");
        check(irq, 0, "R1 irq");
    endtask

    task automatic t_input_pending();
        in_data = 8'hA5; in_strobe = 1;
        step(); idle();
        check(inp_data, 8'hA5, "R2 inp_data");
        check(in_flag, 1, "R2 in_flag");
        step(); step();
        check(in_flag, 1, "R8 flag kept while disabled");
        check(irq, 0, "R8 irq masked");
    endtask

    task automatic t_enable();
        exec_op(S_ION);
        step(); idle();
        check(irq_en, 1, "R7 enable");
        check(irq, 1, "R8 pending raises irq");
    endtask

    task automatic t_skip();
        exec_op(S_SKI); #1;
        check(skip, 1, "R6 skip-in with flag");
        exec_op(S_SKO); #1;
        check(skip, 0, "R6 skip-out without flag");
        step(); idle();
    endtask

    task automatic t_read_input();
        exec_op(S_INP); #1;
        check(inp_load, 1, "R4 inp_load");
        check(inp_data, 8'hA5, "R4 inp_data");
        step(); idle();
        check(in_flag, 0, "R4 in_flag cleared");
        check(irq, 0, "R8 irq drops");
    endtask

    task automatic t_output_req();
        out_req = 1;
        step(); idle();
        check(out_flag, 1, "R3 out_flag");
        exec_op(S_SKO); #1;
        check(skip, 1, "R6 skip-out with flag");
        step(); idle();
    endtask

    task automatic t_ignored();
        acc_lo = 8'h3C; io_exec = 0; io_sel = 6'h3F; #1;
        check(skip, 0, "R10 no skip");
        check(inp_load, 0, "R10 no load");
        step(); idle();
        check(out_flag, 1, "R10 out_flag kept");
        check(irq_en, 1, "R10 enable kept");
        check(out_valid, 0, "R10 no out_valid");
        check(out_data, 0, "R10 out_data kept");
    endtask

    task automatic t_write_output();
        acc_lo = 8'h3C; exec_op(S_OUT);
        step(); idle();
        check(out_valid, 1, "R5 out_valid");
        check(out_data, 8'h3C, "R5 out_data");
        check(out_flag, 0, "R5 out_flag cleared");
        step();
        check(out_valid, 0, "R5 single pulse");
        check(out_data, 8'h3C, "R5 out_data held");
    endtask

    task automatic t_collide();
        in_data = 8'h11; in_strobe = 1; exec_op(S_INP); #1;
        check(inp_data, 8'hA5, "R4 old byte read in collision");
        step(); idle();
        check(in_flag, 1, "R9 input set wins");
        check(inp_data, 8'h11, "R2 new byte held");
        acc_lo = 8'h77; out_req = 1; exec_op(S_OUT);
        step(); idle();
        check(out_flag, 1, "R9 output set wins");
        check(out_data, 8'h77, "R5 collision transfer");
        check(out_valid, 1, "R5 collision pulse");
    endtask

    task automatic t_enable_priority();
        exec_op(S_ION | S_IOF);
        step(); idle();
        check(irq_en, 0, "R7 disable beats enable");
        check(irq, 0, "R8 irq off when disabled");
        exec_op(S_ION);
        step(); idle();
        check(irq, 1, "R8 irq with both flags");
        exec_op(S_ION); irq_ack = 1;
        step(); idle();
        check(irq_en, 0, "R7 ack beats enable");
        exec_op(S_ION);
        step(); idle();
        irq_ack = 1;
        step(); idle();
        check(irq_en, 0, "R7 ack clears");
    endtask

    initial begin
        idle(); in_data = 0; acc_lo = 0; rst_n = 0;
        step(); step();
        rst_n = 1;
        t_reset();
        t_input_pending();
        t_enable();
        t_skip();
        t_read_input();
        t_output_req();
        t_ignored();
        t_write_output();
        t_collide();
        t_enable_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule